// File: doc/BRIEF.md
# Core Debug Register Port

This block sits on the debug side of a processor core. An external host reaches it over a small request/acknowledge register bus and uses it to halt, resume and reset the core, and to inspect the core's state. The host raises a request with an address, a write flag and write data. It keeps them steady until it sees the acknowledge, then drops the request. The block answers each request with a single acknowledge cycle. Read data is carried in that same cycle.

Eight registers are decoded from a 3-bit address. A command register takes one-hot halt, reset and run bits. A breakpoint register holds a byte fetch address; once the host has written it, the core is halted in the very cycle it presents a fetch at that address. A status register reports whether the core is halted and idle, and whether it has terminated. Three core registers are read directly: condition, fixed-point exception and machine state. General registers are reached indirectly: the host writes an index, the block presents that index to the core, and a read of the data register returns the selected value.

The block has its own active-low debug reset. Its own core-reset output does not clear it.

Top module: `core_dbg_port`

## Requirements
- R1: `ack` goes high in the cycle after an edge that samples `req` high while idle. It stays high for exactly one cycle. It does not rise again until `req` has been sampled low at least once.
- R2: On a read (`we`=0), `rdata` holds the addressed value during the `ack` cycle. In every other cycle `rdata` is zero.
- R3: Writing the command register (address 0) with bit 0 set halts the core, so `core_stop` goes high in the `ack` cycle. It stays high until a write with bit 2 (run) set clears it.
- R4: Writing address 0 with bit 1 set drives `core_rst` high for exactly the `ack` cycle and clears the halted state.
- R5: A write to address 2 stores a byte fetch address and arms the breakpoint. The stored value reads back at address 2. While armed, a cycle with `fetch_valid` high and `fetch_addr` equal to it drives `core_stop` high in that same cycle, and the core stays halted afterwards.
- R6: When a breakpoint hit and a run command fall on the same clock edge, the hit wins and the core stays halted.
- R7: A read of address 1 returns bit 0 = halted and `core_busy` low, and bit 1 = `core_terminated`. All other bits are zero.
- R8: Reads of address 3 return `cr_val` zero-extended. Reads of address 4 return `xer_val`. Reads of address 5 return `msr_val`.
- R9: A write to address 6 sets the general-register index (0 to 31) driven on `gpr_idx`, and that index reads back at address 6. A read of address 7 returns `gpr_data`.
- R10: Writes to addresses 1, 3, 4, 5 and 7 are acknowledged but change nothing. Address 0 reads as zero.
- R11: `dbg_rst_n` low clears the halted state, the breakpoint address and its armed flag, and the index. After it, a fetch at address 0 does not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst_n | input | 1 | Asynchronous active-low debug reset |
| req | input | 1 | Host request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 64 | Write data |
| ack | output | 1 | One-cycle acknowledge |
| rdata | output | 64 | Read data, valid with `ack` |
| core_stop | output | 1 | Halt request to the core |
| core_rst | output | 1 | One-cycle core reset pulse |
| fetch_valid | input | 1 | Core presents a fetch this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| core_busy | input | 1 | Some core unit still busy |
| core_terminated | input | 1 | Core has terminated |
| cr_val | input | 32 | Condition register |
| xer_val | input | 64 | Fixed-point exception register |
| msr_val | input | 64 | Machine-state register |
| gpr_idx | output | 5 | Selected general register |
| gpr_data | input | 64 | Value of the selected general register |

## Verification
Two functions can fall on one clock edge: a breakpoint hit and a host run command. The bench provokes this by first halting the core on the breakpoint. It then holds `fetch_valid` with the matching address through an entire run-command write, so the hit and the command reach the same edge. The result is judged at the ports: `core_stop` must still be high after the acknowledge, and a status read must still report halted. A second run command, issued after the fetch is withdrawn, must release the core.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    RA_CMD   = 3'd0,
    RA_STAT  = 3'd1,
    RA_BRK   = 3'd2,
    RA_CR    = 3'd3,
    RA_XER   = 3'd4,
    RA_MSR   = 3'd5,
    RA_GIDX  = 3'd6,
    RA_GDATA = 3'd7
  } dbg_reg_e;

  localparam int CMD_HALT  = 0;
  localparam int CMD_RESET = 1;
  localparam int CMD_RUN   = 2;

  localparam int ST_HALTED = 0;
  localparam int ST_TERM   = 1;
endpackage

// File: rtl/dbg_bus_hs.sv
module dbg_bus_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic fire,
  output logic ack
);
  logic busy_q, busy_d, ack_d;

  always_comb begin
    fire   = req & ~busy_q;
    ack_d  = fire;
    busy_d = req & (busy_q | fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ack    <= ack_d;
    end
  end

  a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r1_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req));
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl #(
  parameter int FA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_halt,
  input  logic            cmd_reset,
  input  logic            cmd_run,
  input  logic            brk_we,
  input  logic [FA_W-1:0] brk_wdata,
  input  logic            fetch_valid,
  input  logic [FA_W-1:0] fetch_addr,
  output logic [FA_W-1:0] brk_addr,
  output logic            halted,
  output logic            core_stop,
  output logic            core_rst
);
  logic            halt_q, halt_d;
  logic            armed_q, armed_d;
  logic [FA_W-1:0] brk_q, brk_d;
  logic            rst_q, rst_d;
  logic            hit;

  always_comb begin
    hit     = armed_q & fetch_valid & (fetch_addr == brk_q);
    brk_d   = brk_we ? brk_wdata : brk_q;
    armed_d = armed_q | brk_we;
    rst_d   = cmd_reset;
    if (hit || cmd_halt)
      halt_d = 1'b1;
    else if (cmd_reset || cmd_run)
      halt_d = 1'b0;
    else
      halt_d = halt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      armed_q <= 1'b0;
      brk_q   <= '0;
      rst_q   <= 1'b0;
    end else begin
      halt_q  <= halt_d;
      armed_q <= armed_d;
      brk_q   <= brk_d;
      rst_q   <= rst_d;
    end
  end

  assign brk_addr  = brk_q;
  assign halted    = halt_q;
  assign core_stop = halt_q | hit;
  assign core_rst  = rst_q;

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !cmd_run && !cmd_reset) |=> halt_q);
  a_r4_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);
  a_r5_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> halt_q);
  a_r6_hit_beats_run: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd_run) |=> halt_q);
endmodule

// File: rtl/dbg_read_mux.sv
module dbg_read_mux
  import dbg_pkg::*;
#(
  parameter int DW    = 64,
  parameter int FA_W  = 32,
  parameter int CR_W  = 32,
  parameter int IDX_W = 5
) (
  input  logic [2:0]       sel,
  input  logic             halted,
  input  logic             core_busy,
  input  logic             core_terminated,
  input  logic [FA_W-1:0]  brk_addr,
  input  logic [CR_W-1:0]  cr_val,
  input  logic [DW-1:0]    xer_val,
  input  logic [DW-1:0]    msr_val,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    gpr_data,
  output logic [DW-1:0]    value
);
  always_comb begin
    value = '0;
    case (dbg_reg_e'(sel))
      RA_STAT: begin
        value[ST_HALTED] = halted & ~core_busy;
        value[ST_TERM]   = core_terminated;
      end
      RA_BRK:   value[FA_W-1:0]  = brk_addr;
      RA_CR:    value[CR_W-1:0]  = cr_val;
      RA_XER:   value            = xer_val;
      RA_MSR:   value            = msr_val;
      RA_GIDX:  value[IDX_W-1:0] = idx;
      RA_GDATA: value            = gpr_data;
      default:  value            = '0;
    endcase
  end
endmodule

// File: rtl/core_dbg_port.sv
module core_dbg_port
  import dbg_pkg::*;
#(
  parameter int DW    = 64,
  parameter int FA_W  = 32,
  parameter int CR_W  = 32,
  parameter int N_GPR = 32,
  localparam int IDX_W = $clog2(N_GPR)
) (
  input  logic             clk,
  input  logic             dbg_rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic             ack,
  output logic [DW-1:0]    rdata,
  output logic             core_stop,
  output logic             core_rst,
  input  logic             fetch_valid,
  input  logic [FA_W-1:0]  fetch_addr,
  input  logic             core_busy,
  input  logic             core_terminated,
  input  logic [CR_W-1:0]  cr_val,
  input  logic [DW-1:0]    xer_val,
  input  logic [DW-1:0]    msr_val,
  output logic [IDX_W-1:0] gpr_idx,
  input  logic [DW-1:0]    gpr_data
);
  logic             fire;
  logic             wr_cmd, wr_brk, wr_idx;
  logic             halted;
  logic [FA_W-1:0]  brk_addr;
  logic [DW-1:0]    rd_val;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  dbg_bus_hs u_hs (
    .clk   (clk),
    .rst_n (dbg_rst_n),
    .req   (req),
    .fire  (fire),
    .ack   (ack)
  );

  always_comb begin
    wr_cmd = fire & we & (addr == RA_CMD);
    wr_brk = fire & we & (addr == RA_BRK);
    wr_idx = fire & we & (addr == RA_GIDX);
  end

  dbg_run_ctrl #(.FA_W(FA_W)) u_run (
    .clk         (clk),
    .rst_n       (dbg_rst_n),
    .cmd_halt    (wr_cmd & wdata[CMD_HALT]),
    .cmd_reset   (wr_cmd & wdata[CMD_RESET]),
    .cmd_run     (wr_cmd & wdata[CMD_RUN]),
    .brk_we      (wr_brk),
    .brk_wdata   (wdata[FA_W-1:0]),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .brk_addr    (brk_addr),
    .halted      (halted),
    .core_stop   (core_stop),
    .core_rst    (core_rst)
  );

  dbg_read_mux #(.DW(DW), .FA_W(FA_W), .CR_W(CR_W), .IDX_W(IDX_W)) u_mux (
    .sel             (addr),
    .halted          (halted),
    .core_busy       (core_busy),
    .core_terminated (core_terminated),
    .brk_addr        (brk_addr),
    .cr_val          (cr_val),
    .xer_val         (xer_val),
    .msr_val         (msr_val),
    .idx             (idx_q),
    .gpr_data        (gpr_data),
    .value           (rd_val)
  );

  always_comb begin
    idx_d   = wr_idx ? wdata[IDX_W-1:0] : idx_q;
    rdata_d = (fire && !we) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge dbg_rst_n) begin
    if (!dbg_rst_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      idx_q   <= idx_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign gpr_idx = idx_q;

  a_r2_rdata_quiet: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    !ack |-> (rdata == '0));
  a_r4_rst_with_ack: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    core_rst |-> ack);
endmodule

// File: tb/sim_core_dbg_port.sv
module sim_core_dbg_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        dbg_rst_n;
  logic        req, we;
  logic [2:0]  addr;
  logic [63:0] wdata, rdata, xer_val, msr_val, gpr_data;
  logic        ack, core_stop, core_rst;
  logic        fetch_valid, core_busy, core_terminated;
  logic [31:0] fetch_addr, cr_val;
  logic [4:0]  gpr_idx;

  int checks = 0;
  int fails  = 0;
  logic [63:0] rd;
  logic        rst_seen;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] gpr_model(input logic [4:0] i);
    return 64'h5EED_0000_0000_0000 | (64'(i) * 64'h0101_0101);
  endfunction
  assign gpr_data = gpr_model(gpr_idx);

  core_dbg_port u0 (
    .clk(clk), .dbg_rst_n(dbg_rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .core_stop(core_stop),
    .core_rst(core_rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .core_busy(core_busy), .core_terminated(core_terminated),
    .cr_val(cr_val), .xer_val(xer_val), .msr_val(msr_val),
    .gpr_idx(gpr_idx), .gpr_data(gpr_data));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transaction; returns read data captured in the ack cycle.
  task automatic xfer(input logic w, input logic [2:0] a, input logic [63:0] d,
                      output logic [63:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    rst_seen = 1'b0;
    r = '0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (core_rst) rst_seen = 1'b1;
      if (ack) begin r = rdata; break; end
    end
    req = 1'b0; addr = '0; we = 1'b0; wdata = '0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R1 ack idle", 64'(ack), 0);
    check("R2 rdata idle", rdata, 0);
    check("R3 stop idle", 64'(core_stop), 0);
    check("R11 idx idle", 64'(gpr_idx), 0);
  endtask

  task automatic t_handshake();
    int acks = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 3'd3;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (ack) acks++;
    end
    check("R1 single ack while req held", 64'(acks), 1);
    req = 1'b0;
    @(negedge clk);
    check("R2 rdata zero after ack", rdata, 0);
  endtask

  task automatic t_halt_run();
    xfer(1, 3'd0, 64'h1, rd);
    check("R3 halt sets stop", 64'(core_stop), 1);
    xfer(0, 3'd1, 0, rd);
    check("R7 status halted", rd, 64'h1);
    xfer(0, 3'd0, 0, rd);
    check("R10 cmd reads zero", rd, 0);
    xfer(1, 3'd0, 64'h4, rd);
    check("R3 run clears stop", 64'(core_stop), 0);
  endtask

  task automatic t_core_reset();
    xfer(1, 3'd0, 64'h1, rd);
    xfer(1, 3'd0, 64'h2, rd);
    check("R4 reset pulse seen with ack", 64'(rst_seen), 1);
    check("R4 reset pulse ended", 64'(core_rst), 0);
    check("R4 reset clears halt", 64'(core_stop), 0);
  endtask

  task automatic t_breakpoint();
    xfer(1, 3'd2, 64'h100, rd);
    xfer(0, 3'd2, 0, rd);
    check("R5 brk readback", rd, 64'h100);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 32'h0FC;
    #1 check("R5 other addr no stop", 64'(core_stop), 0);
    @(negedge clk);
    fetch_addr = 32'h100;
    #1 check("R5 same-cycle stop", 64'(core_stop), 1);
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = '0;
    #1 check("R5 stop held", 64'(core_stop), 1);
  endtask

  task automatic t_collision();
    fetch_valid = 1'b1; fetch_addr = 32'h100;
    xfer(1, 3'd0, 64'h4, rd);
    fetch_valid = 1'b0; fetch_addr = '0;
    #1 check("R6 hit beats run", 64'(core_stop), 1);
    xfer(0, 3'd1, 0, rd);
    check("R6 status still halted", rd, 64'h1);
    xfer(1, 3'd0, 64'h4, rd);
    check("R6 later run releases", 64'(core_stop), 0);
  endtask

  task automatic t_status();
    xfer(1, 3'd0, 64'h1, rd);
    core_busy = 1'b1;
    xfer(0, 3'd1, 0, rd);
    check("R7 busy masks halted", rd, 0);
    core_busy = 1'b0; core_terminated = 1'b1;
    xfer(0, 3'd1, 0, rd);
    check("R7 halted and terminated", rd, 64'h3);
    core_terminated = 1'b0;
    xfer(1, 3'd0, 64'h4, rd);
  endtask

  task automatic t_direct();
    xfer(0, 3'd3, 0, rd); check("R8 cr", rd, 64'h0000_0000_8421_ABCD);
    xfer(0, 3'd4, 0, rd); check("R8 xer", rd, 64'hC000_0000_2000_0001);
    xfer(0, 3'd5, 0, rd); check("R8 msr", rd, 64'h9000_0000_0000_1033);
  endtask

  task automatic t_gpr();
    for (int i = 0; i < 32; i += 13) begin
      xfer(1, 3'd6, 64'(i), rd);
      check("R9 idx port", 64'(gpr_idx), 64'(i));
      xfer(0, 3'd6, 0, rd);
      check("R9 idx readback", rd, 64'(i));
      xfer(0, 3'd7, 0, rd);
      check("R9 data", rd, gpr_model(5'(i)));
    end
    xfer(1, 3'd6, 64'd31, rd);
    xfer(0, 3'd7, 0, rd);
    check("R9 data idx31", rd, gpr_model(5'd31));
  endtask

  task automatic t_readonly();
    xfer(1, 3'd1, 64'h1, rd);
    check("R10 stat write no halt", 64'(core_stop), 0);
    xfer(1, 3'd3, 64'hFFFF, rd);
    xfer(0, 3'd3, 0, rd);
    check("R10 cr unchanged", rd, 64'h0000_0000_8421_ABCD);
    xfer(1, 3'd7, 64'h3, rd);
    check("R10 gdata write keeps idx", 64'(gpr_idx), 31);
  endtask

  task automatic t_dbg_reset();
    xfer(1, 3'd0, 64'h1, rd);
    @(negedge clk); dbg_rst_n = 1'b0;
    @(negedge clk); dbg_rst_n = 1'b1;
    check("R11 halt cleared", 64'(core_stop), 0);
    check("R11 idx cleared", 64'(gpr_idx), 0);
    xfer(0, 3'd2, 0, rd);
    check("R11 brk cleared", rd, 0);
    fetch_valid = 1'b1; fetch_addr = 32'h0;
    @(negedge clk);
    check("R11 unarmed no stop", 64'(core_stop), 0);
    fetch_valid = 1'b0;
  endtask

  initial begin
    dbg_rst_n = 1'b0; req = 0; we = 0; addr = 0; wdata = 0;
    fetch_valid = 0; fetch_addr = 0; core_busy = 0; core_terminated = 0;
    cr_val = 32'h8421_ABCD; xer_val = 64'hC000_0000_2000_0001;
    msr_val = 64'h9000_0000_0000_1033;
    repeat (3) @(negedge clk);
    dbg_rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_handshake();
    t_halt_run();
    t_core_reset();
    t_breakpoint();
    t_collision();
    t_status();
    t_direct();
    t_gpr();
    t_readonly();
    t_dbg_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule